// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits in the memory-access stage of one hart and holds that hart's single reservation for atomic load-reserved (LR) and store-conditional (SC) operations. An LR captures a start address, a byte count (4 for a word, 8 for a doubleword) and a valid flag. From then on, three write sources are watched for a byte-range overlap with the reserved set: ordinary stores issued by this hart, stores snooped from other harts, and writes from non-hart bus agents.

When an SC arrives, the block decides in the same cycle whether it succeeds. The reservation must still be valid. No external write may overlap it in that cycle. Every byte the SC touches must lie inside the reserved set. On success the block enables the memory write and presents the store data, with a word SC carrying only its low 32 bits. The destination-register value is 0 on success and 1 on failure. Every SC ends the reservation. The block also forms the LR's register write-back value, sign-extending a word result.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset `res_valid` is 0, and an SC with no intervening LR fails.
- R2: An LR (`req_kind`=2'b10) sets `res_valid` from the next cycle. The reserved byte count is 4 when `req_dw`=0 and 8 when `req_dw`=1.
- R3: An SC (`req_kind`=2'b11) that fails keeps `sc_mem_we` at 0 and drives `rd_we`=1 with `rd_wdata`=1. An SC that passes drives `sc_mem_we`=1 and `rd_wdata`=0.
- R4: Every SC clears `res_valid` for the following cycle, whether it passes or fails.
- R5: A snooped store from another hart (`snp_valid`) clears the reservation when it overlaps any reserved byte. A non-overlapping snoop leaves it intact.
- R6: A non-hart device write (`dev_valid`) clears the reservation when it overlaps any reserved byte. A non-overlapping one leaves it intact.
- R7: An ordinary store by this hart (`req_kind`=2'b01) clears the reservation only when it overlaps it. Its size is 4 bytes when `req_dw`=0 and 8 bytes when `req_dw`=1.
- R8: A new LR replaces any existing reservation. An SC then pairs only with the newest reserved range.
- R9: An SC passes only if all its bytes lie within the reserved set. That set may come from an LR of a different address and size.
- R10: For an LR, `rd_wdata` is the sign extension of `mem_rdata[31:0]` when `req_dw`=0, and all of `mem_rdata` when `req_dw`=1.
- R11: On a passing SC, `mem_wdata` equals `{32'b0, req_wdata[31:0]}` for a word and `req_wdata` for a doubleword.
- R12: An external write that overlaps in the same cycle as an SC makes that SC fail. An external write in the same cycle as an LR does not affect the new reservation.
- R13: An ordinary load (`req_kind`=2'b00) leaves the reservation and all outputs unchanged: `rd_we` and `sc_mem_we` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | This hart's memory request is valid |
| req_kind | input | 2 | 00 load, 01 store, 10 LR, 11 SC |
| req_dw | input | 1 | 0 word (4 bytes), 1 doubleword (8 bytes) |
| req_addr | input | AW | Request byte address |
| req_wdata | input | XLEN | Store data from the source register |
| mem_rdata | input | XLEN | Data read from memory for an LR |
| snp_valid | input | 1 | Store from another hart observed |
| snp_addr | input | AW | Snooped store start address |
| snp_len | input | LW | Snooped store byte count |
| dev_valid | input | 1 | Write from a non-hart agent observed |
| dev_addr | input | AW | Device write start address |
| dev_len | input | LW | Device write byte count |
| res_valid | output | 1 | Reservation currently held |
| sc_mem_we | output | 1 | Memory write enable for a passing SC |
| mem_wdata | output | XLEN | Data for the SC memory write |
| rd_we | output | 1 | Destination-register write for LR or SC |
| rd_wdata | output | XLEN | Destination-register value |

## Verification
The assertions take for granted that snoop and device lengths are non-zero and that no address range wraps past the top of the address space. They also assume at most one request per cycle from this hart. The stimulus stays inside these limits. It uses small aligned-to-arbitrary addresses far from the top, and byte counts of 1 to 8, and it drives a new request at most once per clock.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    K_LOAD  = 2'b00,
    K_STORE = 2'b01,
    K_LR    = 2'b10,
    K_SC    = 2'b11
  } req_kind_e;

  // byte count of a hart access
  function automatic logic [4:0] acc_bytes(input logic dw);
    return dw ? 5'd8 : 5'd4;
  endfunction

  // two byte ranges share at least one byte
  function automatic logic ranges_overlap(input logic [63:0] a, input logic [4:0] alen,
                                          input logic [63:0] b, input logic [4:0] blen);
    logic [64:0] a_end;
    logic [64:0] b_end;
    a_end = {1'b0, a} + {60'b0, alen};
    b_end = {1'b0, b} + {60'b0, blen};
    return ({1'b0, a} < b_end) && (a_end > {1'b0, b});
  endfunction

  // range a lies wholly inside range b
  function automatic logic range_inside(input logic [63:0] a, input logic [4:0] alen,
                                        input logic [63:0] b, input logic [4:0] blen);
    logic [64:0] a_end;
    logic [64:0] b_end;
    a_end = {1'b0, a} + {60'b0, alen};
    b_end = {1'b0, b} + {60'b0, blen};
    return (a >= b) && (a_end <= b_end);
  endfunction

endpackage

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [AW-1:0] set_addr,
  input  logic [4:0]    set_num,
  output logic          res_valid_o,
  output logic [AW-1:0] res_addr_o,
  output logic [4:0]    res_num_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_addr_o  <= '0;
      res_num_o   <= '0;
    end else if (set_i) begin
      res_valid_o <= 1'b1;
      res_addr_o  <= set_addr;
      res_num_o   <= set_num;
    end else if (clr_i) begin
      res_valid_o <= 1'b0;
    end
  end

  a_r2_lr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> res_valid_o);

  a_r2_size: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (res_num_o == 5'd4 || res_num_o == 5'd8));

endmodule

// File: rtl/lrsc_hit.sv
module lrsc_hit #(
  parameter int AW = 32
) (
  input  logic          src_v,
  input  logic [AW-1:0] src_addr,
  input  logic [4:0]    src_len,
  input  logic          res_valid,
  input  logic [AW-1:0] res_addr,
  input  logic [4:0]    res_num,
  output logic          hit_o
);
  import lrsc_pkg::*;

  always_comb begin
    hit_o = src_v && res_valid &&
            ranges_overlap(64'(src_addr), src_len, 64'(res_addr), res_num);
  end

endmodule

// File: rtl/lrsc_datapath.sv
module lrsc_datapath #(
  parameter int XLEN = 64
) (
  input  logic            is_lr,
  input  logic            is_sc,
  input  logic            dw,
  input  logic            sc_pass,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic [XLEN-1:0] st_data,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_wdata,
  output logic [XLEN-1:0] wr_data
);

  always_comb begin
    rd_we    = is_lr | is_sc;
    rd_wdata = '0;
    if (is_lr)
      rd_wdata = dw ? mem_rdata : {{(XLEN-32){mem_rdata[31]}}, mem_rdata[31:0]};
    else if (is_sc)
      rd_wdata = sc_pass ? '0 : XLEN'(1);
    wr_data = dw ? st_data : {{(XLEN-32){1'b0}}, st_data[31:0]};
  end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int AW   = 32,
  parameter int XLEN = 64,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            req_dw,
  input  logic [AW-1:0]   req_addr,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            snp_valid,
  input  logic [AW-1:0]   snp_addr,
  input  logic [LW-1:0]   snp_len,
  input  logic            dev_valid,
  input  logic [AW-1:0]   dev_addr,
  input  logic [LW-1:0]   dev_len,
  output logic            res_valid,
  output logic            sc_mem_we,
  output logic [XLEN-1:0] mem_wdata,
  output logic            rd_we,
  output logic [XLEN-1:0] rd_wdata
);
  import lrsc_pkg::*;

  localparam int NSRC = 3; // 0 own store, 1 other hart, 2 device

  req_kind_e     kind;
  logic          is_lr, is_sc, is_st;
  logic [4:0]    req_len;
  logic [AW-1:0] res_addr;
  logic [4:0]    res_num;
  logic [NSRC-1:0]          src_v;
  logic [NSRC-1:0][AW-1:0]  src_addr;
  logic [NSRC-1:0][4:0]     src_len;
  logic [NSRC-1:0]          hit;
  logic          ext_hit;
  logic          sc_inside;
  logic          sc_pass;
  logic          res_clr;

  always_comb begin
    kind    = req_kind_e'(req_kind);
    is_lr   = req_valid && (kind == K_LR);
    is_sc   = req_valid && (kind == K_SC);
    is_st   = req_valid && (kind == K_STORE);
    req_len = acc_bytes(req_dw);
    src_v    = {dev_valid, snp_valid, is_st};
    src_addr = {dev_addr, snp_addr, req_addr};
    src_len  = {5'(dev_len), 5'(snp_len), req_len};
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    lrsc_hit #(.AW(AW)) u_hit (
      .src_v    (src_v[g]),
      .src_addr (src_addr[g]),
      .src_len  (src_len[g]),
      .res_valid(res_valid),
      .res_addr (res_addr),
      .res_num  (res_num),
      .hit_o    (hit[g])
    );
  end

  always_comb begin
    ext_hit   = hit[1] | hit[2];
    sc_inside = range_inside(64'(req_addr), req_len, 64'(res_addr), res_num);
    sc_pass   = is_sc && res_valid && sc_inside && !ext_hit;
    res_clr   = is_sc | (|hit);
    sc_mem_we = sc_pass;
  end

  lrsc_resv_reg #(.AW(AW)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (is_lr),
    .clr_i      (res_clr),
    .set_addr   (req_addr),
    .set_num    (req_len),
    .res_valid_o(res_valid),
    .res_addr_o (res_addr),
    .res_num_o  (res_num)
  );

  lrsc_datapath #(.XLEN(XLEN)) u_dp (
    .is_lr    (is_lr),
    .is_sc    (is_sc),
    .dw       (req_dw),
    .sc_pass  (sc_pass),
    .mem_rdata(mem_rdata),
    .st_data  (req_wdata),
    .rd_we    (rd_we),
    .rd_wdata (rd_wdata),
    .wr_data  (mem_wdata)
  );

  a_r1_pass_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
    sc_mem_we |-> res_valid);

  a_r3_sc_code: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |-> (rd_we && rd_wdata == (sc_mem_we ? '0 : XLEN'(1))));

  a_r4_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && !is_lr) |=> !res_valid);

  a_r5_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && !is_lr) |=> !res_valid);

  a_r6_dev_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[2] && !is_lr) |=> !res_valid);

  a_r7_own_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> !res_valid);

  a_r11_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_mem_we && !req_dw) |-> (mem_wdata[XLEN-1:32] == '0));

  a_r12_ext_fails_sc: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |-> !sc_mem_we);

  a_r13_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == K_LOAD) |-> (!rd_we && !sc_mem_we));

endmodule

// File: tb/lrsc_monitor_tb.sv
`timescale 1ns/1ps
module lrsc_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_dw = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] mem_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic [3:0]  snp_len = 4'd4;
  logic        dev_valid = 1'b0;
  logic [31:0] dev_addr = '0;
  logic [3:0]  dev_len = 4'd4;
  logic        res_valid, sc_mem_we, rd_we;
  logic [63:0] mem_wdata, rd_wdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  bit     m_valid = 0;
  longint m_addr = 0;
  int     m_num = 0;

  always #2.5 clk = ~clk;

  lrsc_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_dw(req_dw), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_len(snp_len), .dev_valid(dev_valid), .dev_addr(dev_addr),
    .dev_len(dev_len), .res_valid(res_valid), .sc_mem_we(sc_mem_we),
    .mem_wdata(mem_wdata), .rd_we(rd_we), .rd_wdata(rd_wdata)
  );

  function automatic bit shares(longint a, int al, longint b, int bl);
    return !((a + al <= b) || (b + bl <= a));
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance the model at posedge
  task automatic step(string tag, bit v, logic [1:0] k, bit dw, longint a,
                      logic [63:0] wd, logic [63:0] rd,
                      bit sv, longint sa, int sl, bit dv, longint da, int dl);
    int     len;
    bit     e_pass, e_rdwe, s_hit, d_hit, o_hit;
    logic [63:0] e_rd, e_wd;
    @(negedge clk);
    req_valid = v; req_kind = k; req_dw = dw; req_addr = 32'(a);
    req_wdata = wd; mem_rdata = rd;
    snp_valid = sv; snp_addr = 32'(sa); snp_len = 4'(sl);
    dev_valid = dv; dev_addr = 32'(da); dev_len = 4'(dl);
    #1;
    len   = dw ? 8 : 4;
    s_hit = sv && m_valid && shares(sa, sl, m_addr, m_num);
    d_hit = dv && m_valid && shares(da, dl, m_addr, m_num);
    o_hit = v && k == 2'b01 && m_valid && shares(a, len, m_addr, m_num);
    e_pass = v && k == 2'b11 && m_valid && !s_hit && !d_hit &&
             a >= m_addr && a + len <= m_addr + m_num;
    e_rdwe = v && (k == 2'b10 || k == 2'b11);
    if (v && k == 2'b10) e_rd = dw ? rd : {{32{rd[31]}}, rd[31:0]};
    else e_rd = e_pass ? 64'd0 : 64'd1;
    e_wd = dw ? wd : {32'd0, wd[31:0]};
    check(tag, "res_valid", 64'(res_valid), 64'(m_valid));
    check(tag, "rd_we", 64'(rd_we), 64'(e_rdwe));
    check(tag, "sc_mem_we", 64'(sc_mem_we), 64'(e_pass));
    if (e_rdwe) check(tag, "rd_wdata", rd_wdata, e_rd);
    if (e_pass) check(tag, "mem_wdata", mem_wdata, e_wd);
    @(posedge clk);
    if (v && k == 2'b10) begin
      m_valid = 1; m_addr = a; m_num = len;
    end else if ((v && k == 2'b11) || s_hit || d_hit || o_hit) begin
      m_valid = 0;
    end
  endtask

  task automatic rq(string tag, logic [1:0] k, bit dw, longint a,
                    logic [63:0] wd, logic [63:0] rd);
    step(tag, 1, k, dw, a, wd, rd, 0, 0, 4, 0, 0, 4);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", "res_valid at reset", 64'(res_valid), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    // R1: SC without LR fails
    rq("R1", 2'b11, 0, 'h100, 64'h1, 0);
    // R2 R10 R11: LR.W then SC.W passes with masked data
    rq("R10", 2'b10, 0, 'h100, 0, 64'h0000_0000_8000_0001);
    rq("R11", 2'b11, 0, 'h100, 64'hAAAA_BBBB_1234_5678, 0);
    rq("R4", 2'b11, 0, 'h100, 64'h5, 0);
    rq("R3", 2'b00, 0, 'h0, 0, 0);
    // R9: LR.D covers an inner word SC
    rq("R10", 2'b10, 1, 'h200, 0, 64'h8123_4567_89AB_CDEF);
    rq("R9", 2'b11, 0, 'h204, 64'h77, 0);
    // R9: SC.D outside an LR.W set fails
    rq("R2", 2'b10, 0, 'h300, 0, 64'h7FFF_FFFF);
    rq("R9", 2'b11, 1, 'h300, 64'h99, 0);
    // R5 snoop from other hart
    rq("R5", 2'b10, 0, 'h400, 0, 0);
    step("R5", 0, 2'b00, 0, 0, 0, 0, 1, 'h404, 4, 0, 0, 4);
    step("R5", 0, 2'b00, 0, 0, 0, 0, 1, 'h403, 2, 0, 0, 4);
    rq("R5", 2'b11, 0, 'h400, 64'h1, 0);
    // R6 device writes
    rq("R6", 2'b10, 1, 'h500, 0, 0);
    step("R6", 0, 2'b00, 0, 0, 0, 0, 0, 0, 4, 1, 'h4FC, 4);
    step("R6", 0, 2'b00, 0, 0, 0, 0, 0, 0, 4, 1, 'h4FE, 4);
    rq("R6", 2'b11, 1, 'h500, 64'h1, 0);
    // R7 own stores
    rq("R7", 2'b10, 0, 'h600, 0, 0);
    rq("R7", 2'b01, 0, 'h604, 64'h3, 0);
    rq("R7", 2'b11, 0, 'h600, 64'h4, 0);
    rq("R7", 2'b10, 0, 'h600, 0, 0);
    rq("R7", 2'b01, 0, 'h602, 64'h3, 0);
    rq("R7", 2'b11, 0, 'h600, 64'h4, 0);
    // R13 load has no effect; SC.D passes with full data
    rq("R13", 2'b10, 1, 'h700, 0, 0);
    rq("R13", 2'b00, 1, 'h700, 0, 64'hFFFF);
    rq("R11", 2'b11, 1, 'h700, 64'hDEAD_BEEF_CAFE_F00D, 0);
    // R8 newest LR wins
    rq("R8", 2'b10, 0, 'h800, 0, 0);
    rq("R8", 2'b10, 0, 'h900, 0, 0);
    rq("R8", 2'b11, 0, 'h800, 64'h1, 0);
    rq("R8", 2'b10, 0, 'h800, 0, 0);
    rq("R8", 2'b10, 0, 'h900, 0, 0);
    rq("R8", 2'b11, 0, 'h900, 64'h2, 0);
    // R12 same-cycle external writes
    rq("R12", 2'b10, 0, 'hA00, 0, 0);
    step("R12", 1, 2'b11, 0, 'hA00, 64'h3, 0, 1, 'hA00, 1, 0, 0, 4);
    step("R12", 1, 2'b10, 0, 'hB00, 0, 0, 0, 0, 4, 1, 'hB00, 4);
    rq("R12", 2'b11, 0, 'hB00, 64'h4, 0);
    rq("R4", 2'b00, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule